// File: doc/BRIEF.md
# Serial Bit Error Rate Checker

This block examines a serial bit stream, one bit per cycle in which `bit_en` is high, and compares it against a repeating 32-bit reference pattern held in a host register. It first hunts for alignment. Once 32 consecutive received bits agree with some rotation of the reference, it locks to that rotation. From then on it counts every examined bit and every mismatched bit. The host divides the two counts to obtain the error ratio.

A controller hunts in state HUNT. Transition ACQUIRE moves it to LOCK when a full 32-bit run agrees with a rotation. Transition DROP returns it to HUNT when too many errors fall inside one window. Both counts are held in running counters that saturate. A rising edge on a control bit copies both counts into registers the host can read, and the same edge restarts the counters. Two sticky flags record whether ACQUIRE or DROP has happened since the host last cleared them.

The host sees a small register file:

| Address | Contents |
|---|---|
| 0 | Reference pattern |
| 1 | Control; bit 0 is the capture bit |
| 2 | Status |
| 3 | Held bit count |
| 4 | Held error count |

Writes take effect at the clock edge. Reads are combinational on `reg_addr`.

Top module: `bert_checker`

## Requirements
- R1: Address 0 holds the 32-bit reference pattern and reads back what was written. The stream is expected to carry pattern bit 0 first, then bit 1, up to bit 31, and then to repeat. A shorter pattern must be written repeated so that it fills all 32 bits.
- R2: The checker leaves HUNT only after at least 32 bits have been received since it entered HUNT, and the last 32 of them match a rotation of the pattern. ACQUIRE then sets status bit 0. A run of 31 matching bits does not set it.
- R3: In LOCK, each received bit is compared with the next pattern bit in rotation order. Every examined bit adds one to the bit count. Every mismatch also adds one to the error count.
- R4: With pattern 0x5555_5555 (alternating), a received stream that locks to it counts one error for each single bit that breaks the alternation.
- R5: In LOCK, the windows are 64 examined bits long and are aligned to the moment of ACQUIRE. When the sixth error inside one window arrives, DROP occurs: the checker returns to HUNT and status bit 1 is set. That sixth bit is still counted. A bit that matches never causes DROP.
- R6: Bits received in HUNT add nothing to either count.
- R7: Both running counters are CNT_W bits wide (32 by default). Each saturates at all-ones instead of wrapping.
- R8: A 0-to-1 change of control bit 0 (address 1) does two things. It copies the running bit count to address 3 and the running error count to address 4. It also restarts both counters from zero. A bit examined in the capture cycle goes into the new run.
- R9: Holding control bit 0 high, or writing 1 to it again, produces no further capture.
- R10: Status bits 0 and 1 are sticky. Writing 1 to a bit at address 2 clears it. If an event arrives in the same cycle as the clear, the event wins and the bit stays set.
- R11: After reset the checker is in HUNT, and the pattern, control, status and held counts all read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Qualifies `bit_in` in this cycle |
| bit_in | input | 1 | Received serial bit |
| reg_wr | input | 1 | Host write strobe |
| reg_addr | input | 3 | Host register address |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data for `reg_addr` |

## Verification
The assertions watch the following on every cycle:
- HUNT is never left before a full 32-bit run has arrived.
- A matching bit never causes DROP.
- The pattern pointer advances by one for each examined bit.
- The error count never exceeds the bit count.
- The counters saturate.
- A sticky flag holds until it is cleared, and an event beats a simultaneous clear.
- Each rising edge of the control bit gives exactly one capture.

Some behaviour needs whole streams and can only be shown by the bench's scenarios:
- The exact count values.
- The point in the stream where lock is gained.
- The sixth-error DROP and the bits ignored after it.
- Single-error counting on the alternating pattern.
- Saturation, checked end to end with a narrow counter.

// File: rtl/bert_pkg.sv
package bert_pkg;

    localparam int REG_ADDR_W = 3;
    localparam int REG_DATA_W = 32;

    localparam logic [REG_ADDR_W-1:0] ADDR_PATTERN   = 3'd0;
    localparam logic [REG_ADDR_W-1:0] ADDR_CTRL      = 3'd1;
    localparam logic [REG_ADDR_W-1:0] ADDR_STATUS    = 3'd2;
    localparam logic [REG_ADDR_W-1:0] ADDR_HELD_BITS = 3'd3;
    localparam logic [REG_ADDR_W-1:0] ADDR_HELD_ERRS = 3'd4;

    typedef enum logic [0:0] {
        ST_HUNT = 1'b0,
        ST_LOCK = 1'b1
    } sync_state_t;

endpackage

// File: rtl/bert_sync_fsm.sv
module bert_sync_fsm
    import bert_pkg::*;
#(
    parameter int PAT_W    = 32,
    parameter int WIN      = 64,
    parameter int LOSS_THR = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             bit_in,
    input  logic [PAT_W-1:0] pattern,
    output logic             locked,
    output logic             cnt_bit,
    output logic             cnt_err,
    output logic             sync_evt,
    output logic             loss_evt
);
    localparam int PTR_W  = $clog2(PAT_W);
    localparam int HUNT_W = $clog2(PAT_W + 1);
    localparam int WIN_W  = $clog2(WIN);
    localparam int WERR_W = $clog2(LOSS_THR + 1);

    sync_state_t st, st_n;

    logic [PAT_W-1:0]             hist, hist_n;
    logic [PAT_W-1:0][PAT_W-1:0]  rot;
    logic [PAT_W-1:0]             hit;
    logic                         any_hit;
    logic [PTR_W-1:0]             hit_idx;
    logic [PTR_W-1:0]             ptr;
    logic [HUNT_W-1:0]            hunt_cnt;
    logic [WIN_W-1:0]             win_cnt;
    logic [WERR_W-1:0]            win_err;
    logic                         mism, hunt_ready, acquire, drop;

    assign hist_n = {hist[PAT_W-2:0], bit_in};

    // One comparator per rotation: rotation p means the next expected bit is pattern[p].
    for (genvar p = 0; p < PAT_W; p++) begin : g_rot
        for (genvar i = 0; i < PAT_W; i++) begin : g_bit
            assign rot[p][PAT_W-1-i] = pattern[(p + i) % PAT_W];
        end
        assign hit[p] = (hist_n == rot[p]);
    end

    always_comb begin
        any_hit = |hit;
        hit_idx = '0;
        for (int k = PAT_W - 1; k >= 0; k--) begin
            if (hit[k]) hit_idx = PTR_W'(k);
        end
    end

    assign mism       = bit_in ^ pattern[ptr];
    assign hunt_ready = (hunt_cnt >= HUNT_W'(PAT_W - 1));

    // Next-state and transition decode.
    always_comb begin
        st_n    = st;
        acquire = 1'b0;
        drop    = 1'b0;
        unique case (st)
            ST_HUNT: begin
                if (bit_en && hunt_ready && any_hit) begin
                    st_n    = ST_LOCK;
                    acquire = 1'b1;
                end
            end
            ST_LOCK: begin
                if (bit_en && mism && ((win_err + WERR_W'(1)) >= WERR_W'(LOSS_THR))) begin
                    st_n = ST_HUNT;
                    drop = 1'b1;
                end
            end
            default: st_n = ST_HUNT;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_HUNT;
        else        st <= st_n;
    end

    // Outputs.
    always_comb begin
        locked   = (st == ST_LOCK);
        cnt_bit  = locked && bit_en;
        cnt_err  = locked && bit_en && mism;
        sync_evt = acquire;
        loss_evt = drop;
    end

    // Alignment pointer, hunt run length and error window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist     <= '0;
            ptr      <= '0;
            hunt_cnt <= '0;
            win_cnt  <= '0;
            win_err  <= '0;
        end else begin
            if (bit_en) hist <= hist_n;
            unique case (st)
                ST_HUNT: begin
                    if (acquire) begin
                        ptr      <= hit_idx;
                        hunt_cnt <= '0;
                        win_cnt  <= '0;
                        win_err  <= '0;
                    end else if (bit_en && hunt_cnt != HUNT_W'(PAT_W)) begin
                        hunt_cnt <= hunt_cnt + 1'b1;
                    end
                end
                ST_LOCK: begin
                    if (bit_en) begin
                        ptr <= (ptr == PTR_W'(PAT_W - 1)) ? '0 : ptr + 1'b1;
                        if (win_cnt == WIN_W'(WIN - 1)) begin
                            win_cnt <= '0;
                            win_err <= '0;
                        end else begin
                            win_cnt <= win_cnt + 1'b1;
                            win_err <= win_err + WERR_W'(mism);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    AST_NO_EARLY_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HUNT && hunt_cnt < HUNT_W'(PAT_W - 1)) |=> (st == ST_HUNT)); // R2
    AST_MATCH_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOCK && bit_en && !mism) |=> (st == ST_LOCK)); // R5
    AST_PTR_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOCK && bit_en && !loss_evt) |=> ptr == PTR_W'((32'($past(ptr)) + 1) % PAT_W)); // R3

endmodule

// File: rtl/bert_counters.sv
module bert_counters #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_bit,
    input  logic             cnt_err,
    input  logic             capture,
    output logic [CNT_W-1:0] held_bits,
    output logic [CNT_W-1:0] held_errs
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] run_bits, run_errs;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_bits  <= '0;
            run_errs  <= '0;
            held_bits <= '0;
            held_errs <= '0;
        end else if (capture) begin
            held_bits <= run_bits;
            held_errs <= run_errs;
            run_bits  <= CNT_W'(cnt_bit);
            run_errs  <= CNT_W'(cnt_err);
        end else begin
            if (cnt_bit && run_bits != CNT_MAX) run_bits <= run_bits + 1'b1;
            if (cnt_err && run_errs != CNT_MAX) run_errs <= run_errs + 1'b1;
        end
    end

    AST_BITS_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_bits == CNT_MAX && !capture) |=> (run_bits == CNT_MAX)); // R7
    AST_ERRS_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_errs == CNT_MAX && !capture) |=> (run_errs == CNT_MAX)); // R7
    AST_ERRS_WITHIN_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        run_errs <= run_bits); // R3

endmodule

// File: rtl/bert_host_regs.sv
module bert_host_regs
    import bert_pkg::*;
#(
    parameter int PAT_W = 32,
    parameter int CNT_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [REG_DATA_W-1:0] wdata,
    input  logic                  sync_evt,
    input  logic                  loss_evt,
    input  logic [CNT_W-1:0]      held_bits,
    input  logic [CNT_W-1:0]      held_errs,
    output logic [REG_DATA_W-1:0] rdata,
    output logic [PAT_W-1:0]      pattern,
    output logic                  capture
);
    logic ctrl_q, ctrl_d;
    logic sync_seen, loss_seen;
    logic wr_status, clr_sync, clr_loss;

    assign wr_status = wr_en && (addr == ADDR_STATUS);
    assign clr_sync  = wr_status && wdata[0];
    assign clr_loss  = wr_status && wdata[1];
    assign capture   = ctrl_q && !ctrl_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pattern   <= '0;
            ctrl_q    <= 1'b0;
            ctrl_d    <= 1'b0;
            sync_seen <= 1'b0;
            loss_seen <= 1'b0;
        end else begin
            ctrl_d <= ctrl_q;
            if (wr_en && addr == ADDR_PATTERN) pattern <= wdata[PAT_W-1:0];
            if (wr_en && addr == ADDR_CTRL)    ctrl_q  <= wdata[0];
            sync_seen <= sync_evt || (sync_seen && !clr_sync);
            loss_seen <= loss_evt || (loss_seen && !clr_loss);
        end
    end

    always_comb begin
        case (addr)
            ADDR_PATTERN:   rdata = REG_DATA_W'(pattern);
            ADDR_CTRL:      rdata = {{(REG_DATA_W-1){1'b0}}, ctrl_q};
            ADDR_STATUS:    rdata = {{(REG_DATA_W-2){1'b0}}, loss_seen, sync_seen};
            ADDR_HELD_BITS: rdata = REG_DATA_W'(held_bits);
            ADDR_HELD_ERRS: rdata = REG_DATA_W'(held_errs);
            default:        rdata = '0;
        endcase
    end

    AST_SYNC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_seen && !clr_sync) |=> sync_seen); // R10
    AST_LOSS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (loss_seen && !clr_loss) |=> loss_seen); // R10
    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_evt || loss_evt) |=> (sync_seen || loss_seen)); // R10

endmodule

// File: rtl/bert_checker.sv
module bert_checker
    import bert_pkg::*;
#(
    parameter int PAT_W    = 32,
    parameter int WIN      = 64,
    parameter int LOSS_THR = 6,
    parameter int CNT_W    = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bit_en,
    input  logic        bit_in,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata
);
    logic [PAT_W-1:0] pattern;
    logic             locked, cnt_bit, cnt_err, sync_evt, loss_evt, capture;
    logic [CNT_W-1:0] held_bits, held_errs;

    bert_sync_fsm #(.PAT_W(PAT_W), .WIN(WIN), .LOSS_THR(LOSS_THR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .pattern(pattern), .locked(locked), .cnt_bit(cnt_bit), .cnt_err(cnt_err),
        .sync_evt(sync_evt), .loss_evt(loss_evt)
    );

    bert_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .cnt_bit(cnt_bit), .cnt_err(cnt_err),
        .capture(capture), .held_bits(held_bits), .held_errs(held_errs)
    );

    bert_host_regs #(.PAT_W(PAT_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .sync_evt(sync_evt), .loss_evt(loss_evt), .held_bits(held_bits),
        .held_errs(held_errs), .rdata(reg_rdata), .pattern(pattern), .capture(capture)
    );

    AST_ONE_CAPTURE_PER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> !capture); // R9
    AST_NO_COUNT_IN_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> !cnt_bit); // R6

endmodule

// File: tb/sim_bert_checker.sv
module sim_bert_checker;
    localparam int CNT_W = 12;
    localparam logic [2:0] A_PAT = 3'd0, A_CTRL = 3'd1, A_STAT = 3'd2, A_HB = 3'd3, A_HE = 3'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        bit_in = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [31:0] pat_cur;
    int phase = 0;
    int gap = 20;

    bert_checker #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] sat_expect(int n);
        return (n > (1 << CNT_W) - 1) ? 32'((1 << CNT_W) - 1) : 32'(n);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            bit_en = 1'b0;
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        bit_en = 1'b0; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bit_en = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic send(logic b);
        @(negedge clk);
        bit_en = 1'b1; bit_in = b;
    endtask

    task automatic send_good(int n);
        for (int k = 0; k < n; k++) begin
            send(pat_cur[phase]);
            phase = (phase + 1) % 32;
        end
    endtask

    task automatic send_bad(int n);
        for (int k = 0; k < n; k++) begin
            send(~pat_cur[phase]);
            phase = (phase + 1) % 32;
        end
    endtask

    task automatic latch();
        wr(A_CTRL, 32'd0);
        wr(A_CTRL, 32'd1);
        idle(3);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd4242));
        idle(5);
        rst_n = 1'b1;
        idle(2);

        // R11 reset state
        rd(A_STAT, d); chk("R11 status", d, 32'd0);
        rd(A_HB, d);   chk("R11 held bits", d, 32'd0);
        rd(A_HE, d);   chk("R11 held errs", d, 32'd0);
        rd(A_PAT, d);  chk("R11 pattern", d, 32'd0);

        // R1 pattern register
        pat_cur = $urandom();
        wr(A_PAT, pat_cur);
        rd(A_PAT, d); chk("R1 pattern readback", d, pat_cur);

        // R2 lock needs 32 matching bits
        phase = int'($urandom() % 32);
        send_good(31); idle(2);
        rd(A_STAT, d); chk("R2 no sync after 31", d, 32'd0);
        send_good(1); idle(2);
        rd(A_STAT, d); chk("R2 sync after 32", d, 32'd1);

        // R8 first capture right after lock
        latch();
        rd(A_HB, d); chk("R8 held bits at lock", d, 32'd0);
        rd(A_HE, d); chk("R8 held errs at lock", d, 32'd0);

        // R5 sixth error drops lock; R6 hunt bits ignored
        send_bad(6);
        send_good(10);
        idle(2);
        rd(A_STAT, d); chk("R5 loss flag", d, 32'd3);
        latch();
        rd(A_HB, d); chk("R6 bits stop at drop", d, 32'd6);
        rd(A_HE, d); chk("R5 errors up to drop", d, 32'd6);

        // R10 write-one-to-clear
        wr(A_STAT, 32'd3);
        rd(A_STAT, d); chk("R10 cleared", d, 32'd0);

        // R2 resync, then restart counts
        send_good(40); idle(2);
        rd(A_STAT, d); chk("R2 resync", d, 32'd1);
        latch();
        gap = 20;

        // R3 constrained random error rounds (at most 4 errors per 64 bits)
        for (int r = 0; r < 4; r++) begin
            int n, e;
            n = 100 + int'($urandom() % 600);
            e = 0;
            for (int k = 0; k < n; k++) begin
                if (gap >= 20 && ($urandom() % 8) == 0) begin
                    send_bad(1); e++; gap = 0;
                end else begin
                    send_good(1); gap++;
                end
            end
            latch();
            rd(A_HB, d); chk("R3 bit count", d, sat_expect(n));
            rd(A_HE, d); chk("R3 error count", d, 32'(e));
            if (r == 0) begin
                // R9 holding the control bit high gives no second capture
                send_good(50); gap += 50;
                wr(A_CTRL, 32'd1); idle(3);
                rd(A_HB, d); chk("R9 no recapture", d, sat_expect(n));
                latch();
                rd(A_HB, d); chk("R8 capture restarts", d, 32'd50);
            end
        end
        rd(A_STAT, d); chk("R5 no loss at low error rate", d, 32'd1);

        // R4 alternating pattern
        send_bad(12); idle(2);
        wr(A_STAT, 32'd3);
        pat_cur = 32'h5555_5555;
        wr(A_PAT, pat_cur);
        phase = 0;
        send_good(40); idle(2);
        rd(A_STAT, d); chk("R4 lock on alternating", d, 32'd1);
        latch();
        for (int k = 0; k < 100; k++) begin
            if (k == 50) send_bad(1);
            else         send_good(1);
        end
        latch();
        rd(A_HB, d); chk("R4 bits", d, 32'd100);
        rd(A_HE, d); chk("R4 single break one error", d, 32'd1);

        // R7 saturation with the narrow bench counter
        send_good(4200);
        latch();
        rd(A_HB, d); chk("R7 bits saturate", d, sat_expect(4200));
        rd(A_HE, d); chk("R7 errs zero", d, 32'd0);

        finish_run();
    end
endmodule